// File: doc/BRIEF.md
# Bipolar Stepper Phase/Enable Sequencer

This block drives the direction and enable inputs of two H-bridges that power the two windings of a bipolar stepping motor. Each rising edge of a step pulse moves the motor one position, forward or backward as the direction input selects. A mode input chooses between full-step operation, where both windings always carry current, and half-step operation, which puts a single-winding position between each pair of two-winding positions.

The sequencer keeps a position index on an eight-entry ring. Full-step mode visits only the even entries, where both windings are driven. Half-step mode visits every entry. A winding that carries no current has its bridge enable dropped. Its direction bit is then meaningless. All three control inputs may be asynchronous to the clock, and each is brought into the clock domain through a synchronizer before it is used.

Top module: `stepper_seq`

## Requirements
- R1: Reset (rst_ni low) sets position 0, where ph_a_o=1, en_a_o=1, ph_b_o=1 and en_b_o=1.
- R2: The positions 0 to 7 drive (ph_a, ph_b) with both enables high at 0 (1,1), 2 (0,1), 4 (0,0) and 6 (1,0). Position 1 has en_a=0 and ph_b=1. Position 3 has en_b=0 and ph_a=0. Position 5 has en_a=0 and ph_b=0. Position 7 has en_b=0 and ph_a=1. A phase bit whose enable is low is don't-care.
- R3: When half_i=0 (full-step mode), each step with dir_i=1 adds 2 to the position modulo 8, giving (ph_a,ph_b) 11, 01, 00, 10, and each step with dir_i=0 subtracts 2.
- R4: When half_i=1 (half-step mode), each step with dir_i=1 adds 1 to the position modulo 8 and each step with dir_i=0 subtracts 1. The sequence therefore alternates between two-winding and one-winding positions.
- R5: The two enables are never low at the same time.
- R6: A change of direction retraces the same positions in reverse order, starting from the current position.
- R7: A step is taken only on a rising edge of step_i after synchronization. Holding step_i high gives exactly one step. The outputs change within four clock edges of the first edge that samples step_i high.
- R8: dir_i is sampled together with the step edge. A change of dir_i with no step leaves the outputs unchanged.
- R9: In full-step mode both enables stay high. On a switch from half-step to full-step mode at an odd position, the position moves to the two-winding position just below it (1→0, 3→2, 5→4, 7→6). A switch from full-step to half-step mode keeps the position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Step request, rising edge active, asynchronous |
| dir_i | input | 1 | 1 = forward, 0 = reverse, asynchronous |
| half_i | input | 1 | 1 = half-step, 0 = full-step, asynchronous |
| ph_a_o | output | 1 | Bridge A current direction |
| en_a_o | output | 1 | Bridge A enable |
| ph_b_o | output | 1 | Bridge B current direction |
| en_b_o | output | 1 | Bridge B enable |

## Verification
The assertions assume that dir_i and half_i settle before the step edge they are meant to go with. Both pass through the same synchronizer depth as step_i, so a direction change that arrives together with a step might pair with either the old or the new value. The bench changes direction and mode only while step_i is low and several clocks away from any step edge. It holds every step pulse high and then low for several clocks, so the synchronizer never misses a pulse.

// File: rtl/stepper_pkg.sv
package stepper_pkg;
  localparam int unsigned POS_W = 3;
  typedef logic [POS_W-1:0] pos_t;

  typedef struct packed {
    logic ph_a;
    logic en_a;
    logic ph_b;
    logic en_b;
  } drive_t;

  // even index: both windings driven; odd: one winding released
  function automatic drive_t pos_to_drive(pos_t p);
    drive_t d;
    d.en_a = !(p == 3'd1 || p == 3'd5);
    d.en_b = !(p == 3'd3 || p == 3'd7);
    d.ph_a = d.en_a && (p == 3'd7 || p == 3'd0 || p == 3'd6);
    d.ph_b = d.en_b && (p == 3'd0 || p == 3'd1 || p == 3'd2);
    return d;
  endfunction
endpackage

// File: rtl/stepper_sync.sv
module stepper_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] q;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) q[s] <= '0;
          else         q[s] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) q[s] <= '0;
          else         q[s] <= q[s-1];
      end
    end
  endgenerate

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/stepper_pos.sv
module stepper_pos
  import stepper_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_s_i,
  input  logic dir_s_i,
  input  logic half_s_i,
  output logic evt_o,
  output pos_t pos_o
);
  logic step_d;
  pos_t pos_q, base, delta, pos_d;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) step_d <= 1'b0;
    else         step_d <= step_s_i;

  assign evt_o = step_s_i & ~step_d;

  // full-step mode works from the two-winding position at or below
  assign base  = half_s_i ? pos_q : {pos_q[POS_W-1:1], 1'b0};
  assign delta = half_s_i ? pos_t'(1) : pos_t'(2);

  always_comb begin
    pos_d = base;
    if (evt_o) pos_d = dir_s_i ? base + delta : base - delta;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) pos_q <= '0;
    else         pos_q <= pos_d;

  assign pos_o = pos_q;
endmodule

// File: rtl/stepper_seq.sv
module stepper_seq
  import stepper_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  input  logic dir_i,
  input  logic half_i,
  output logic ph_a_o,
  output logic en_a_o,
  output logic ph_b_o,
  output logic en_b_o
);
  localparam int unsigned N_IN = 3;

  logic [N_IN-1:0] raw, synced;
  logic   step_s, dir_s, half_q, step_evt;
  pos_t   pos_q;
  drive_t drv;

  assign raw = {half_i, dir_i, step_i};

  stepper_sync #(.WIDTH(N_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (synced)
  );

  assign {half_q, dir_s, step_s} = synced;

  stepper_pos u_pos (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_s_i(step_s),
    .dir_s_i (dir_s),
    .half_s_i(half_q),
    .evt_o   (step_evt),
    .pos_o   (pos_q)
  );

  assign drv    = pos_to_drive(pos_q);
  assign ph_a_o = drv.ph_a;
  assign en_a_o = drv.en_a;
  assign ph_b_o = drv.ph_b;
  assign en_b_o = drv.en_b;
endmodule

// File: rtl/stepper_seq_chk.sv
module stepper_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       step_evt,
  input logic       half_q,
  input logic [2:0] pos_q,
  input logic       ph_a_o,
  input logic       en_a_o,
  input logic       ph_b_o,
  input logic       en_b_o
);
  AST_NEVER_BOTH_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_a_o || en_b_o)); // R5

  AST_FULL_BOTH_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!half_q && !$past(half_q)) |-> (en_a_o && en_b_o)); // R9

  AST_HOLD_NO_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_evt && half_q) |=> $stable({ph_a_o, en_a_o, ph_b_o, en_b_o})); // R8

  AST_HALF_ONE_POS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_evt && half_q) |=> ((3'(pos_q - $past(pos_q)) == 3'd1) ||
                              (3'(pos_q - $past(pos_q)) == 3'd7))); // R4

  AST_FULL_EVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_evt && !half_q) |=> !pos_q[0]); // R3

  AST_EVT_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_evt |=> !step_evt); // R7
endmodule

bind stepper_seq stepper_seq_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .step_evt(step_evt),
  .half_q  (half_q),
  .pos_q   (pos_q),
  .ph_a_o  (ph_a_o),
  .en_a_o  (en_a_o),
  .ph_b_o  (ph_b_o),
  .en_b_o  (en_b_o)
);

// File: tb/sim_stepper_seq.sv
`timescale 1ns/1ps
module sim_stepper_seq;
  logic clk = 1'b0, rst_n = 1'b0, step = 1'b0, dir = 1'b1, half = 1'b0;
  logic ph_a, en_a, ph_b, en_b;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  stepper_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .step_i(step), .dir_i(dir), .half_i(half),
    .ph_a_o(ph_a), .en_a_o(en_a), .ph_b_o(ph_b), .en_b_o(en_b)
  );

  // expected {ph_a,en_a,ph_b,en_b} per position (R2); disabled phase = 0
  function automatic logic [3:0] exp_drv(int p);
    case (p & 7)
      0: return 4'b1111;
      1: return 4'b0011;
      2: return 4'b0111;
      3: return 4'b0100;
      4: return 4'b0101;
      5: return 4'b0001;
      6: return 4'b1101;
      default: return 4'b1100;
    endcase
  endfunction

  task automatic wait_clks(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, int p);
    logic [3:0] got, exp, mask;
    exp  = exp_drv(p);
    got  = {ph_a, en_a, ph_b, en_b};
    mask = {exp[2], 1'b1, exp[0], 1'b1}; // phase don't-care when disabled
    checks++;
    if ((got & mask) !== (exp & mask)) begin
      fails++;
      $display("FAIL %s pos=%0d actual=%b expected=%b", req, p, got, exp);
    end
  endtask

  task automatic pulse(logic d);
    @(negedge clk); dir = d;
    wait_clks(4);
    step = 1'b1; wait_clks(6);
    step = 1'b0; wait_clks(6);
  endtask

  task automatic set_mode(logic h);
    @(negedge clk); half = h;
    wait_clks(6);
  endtask

  task automatic do_reset;
    @(negedge clk); rst_n = 1'b0; step = 1'b0; half = 1'b0; dir = 1'b1;
    wait_clks(3);
    chk("R1 reset", 0);
    rst_n = 1'b1; wait_clks(3);
    chk("R1 after release", 0);
  endtask

  task automatic t_full_fwd;
    do_reset();
    for (int i = 1; i <= 5; i++) begin
      pulse(1'b1);
      chk("R3 full fwd", 2 * i);
    end
  endtask

  task automatic t_full_rev;
    do_reset();
    for (int i = 1; i <= 4; i++) begin
      pulse(1'b0);
      chk("R3 full rev", 8 - 2 * i);
    end
  endtask

  task automatic t_half_fwd;
    do_reset();
    set_mode(1'b1);
    chk("R9 mode keep", 0);
    for (int i = 1; i <= 9; i++) begin
      pulse(1'b1);
      chk("R4 half fwd", i);
      checks++;
      if (!en_a && !en_b) begin
        fails++;
        $display("FAIL R5 actual=00 expected=not both off");
      end
    end
  endtask

  task automatic t_reverse;
    int p;
    do_reset();
    set_mode(1'b1);
    p = 0;
    for (int i = 0; i < 3; i++) begin pulse(1'b1); p++; end
    chk("R6 before turn", 3);
    for (int i = 0; i < 5; i++) begin
      pulse(1'b0); p--;
      chk("R6 retrace", p);
    end
  endtask

  task automatic t_hold_and_dir;
    do_reset();
    set_mode(1'b1);
    @(negedge clk); dir = 1'b1; wait_clks(4);
    step = 1'b1;
    wait_clks(4);
    chk("R7 latency", 1);
    wait_clks(30);
    chk("R7 held high one step", 1);
    step = 1'b0; wait_clks(6);
    dir = 1'b0; wait_clks(10);
    chk("R8 dir no step", 1);
    dir = 1'b1; wait_clks(10);
    chk("R8 dir no step back", 1);
  endtask

  task automatic t_mode_snap;
    do_reset();
    set_mode(1'b1);
    for (int i = 0; i < 5; i++) pulse(1'b1);
    chk("R9 at odd", 5);
    set_mode(1'b0);
    chk("R9 snap down", 4);
    checks++;
    if (!(en_a && en_b)) begin
      fails++;
      $display("FAIL R9 actual=%b%b expected=11", en_a, en_b);
    end
    pulse(1'b1);
    chk("R9 full after snap", 6);
    set_mode(1'b1);
    pulse(1'b1);
    chk("R9 half after full", 7);
  endtask

  initial begin
    t_full_fwd();
    t_full_rev();
    t_half_fwd();
    t_reverse();
    t_hold_and_dir();
    t_mode_snap();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule